// File: doc/BRIEF.md
# Time-Interval Measurement Sequencer

This block runs one time-to-digital measurement channel. In normal operation it passes the first rising edge on the start input and the next rising edge on the stop input to a measuring core. In two calibration modes it passes only edges of an internally divided reference clock. The first calibration mode spans one divided period and the second spans two. The measuring core is modelled as a coarse counter clocked by the system clock.

After every stop the sequencer runs a characteristic-quantity phase whose length scales with a selectable accuracy factor. It then runs a fixed result-calculation phase and raises `ready`. The result and `ready` stay put until the bit that launched the measurement is cleared.

The start, stop and reference-clock inputs are asynchronous. Each passes through a two-flop synchronizer and then a rising-edge detector. Mode, division factor and accuracy settings are captured when a measurement begins.

Top module: `tdc_seq`

## Requirements
- R1: In time mode (`chan_en`=1), `coarse_cnt` ends equal to the number of clock cycles from the START rising edge to the next STOP rising edge. Both inputs go through the same synchronizer delay. STOP edges that come before the START edge are ignored.
- R2: With `chan_en`=0 and no calibration request, edges on START and STOP have no effect: `busy` and `ready` stay 0.
- R3: A CAL1 request (`cal1_req`=1 with `chan_en`=0) measures one period of the divided reference clock, so `coarse_cnt` = N·P, where P is the reference-clock period in system cycles. START and STOP are ignored while it runs.
- R4: A CAL2 request (`cal2_req`=1 with `chan_en`=0) measures two divided periods, so `coarse_cnt` = 2·N·P.
- R5: `div_sel` values 0, 1, 2 and 3 select a divide factor N of 1, 2, 4 and 8 respectively.
- R6: `ready` is first observed high after the (L + CALC_CYC + 3)-th rising clock edge following the STOP input going high. Here L = BASE_CYC·(1 + 8·A). A is 1, 4, 16 or 32 for `acc_sel` = 0, 1, 2 or 3, and A = 0 when `char_en` = 0.
- R7: `ready`, `coarse_cnt` and `core_ovf` hold while the triggering bit stays set. One cycle after that bit clears, `ready` is 0.
- R8: Further START or STOP edges after the stop has been taken, or further START edges during counting, do not change the result.
- R9: If `coarse_cnt` reaches all ones before a stop arrives, `core_ovf` is set, `coarse_cnt` stays all ones and the sequence still ends with `ready`. The next measurement clears `core_ovf` when it begins.
- R10: Calibration requests are ignored while `chan_en`=1. When both requests are set with `chan_en`=0, CAL1 takes precedence.
- R11: Clearing the triggering bit while waiting for a start or stop abandons the measurement: `busy` drops and `ready` never rises.
- R12: After reset `ready`, `busy`, `core_ovf` and `coarse_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; launches a time measurement |
| cal1_req | input | 1 | One-period calibration request |
| cal2_req | input | 1 | Two-period calibration request |
| char_en | input | 1 | Enable characteristic-quantity phase |
| acc_sel | input | 2 | Accuracy select (1/4/16/32-fold) |
| div_sel | input | 2 | Reference-clock divide select (1/2/4/8) |
| start_in | input | 1 | Asynchronous start input |
| stop_in | input | 1 | Asynchronous stop input |
| cal_clk_in | input | 1 | Asynchronous reference clock |
| ready | output | 1 | Result valid |
| busy | output | 1 | Counting or post-processing in progress |
| core_ovf | output | 1 | Coarse counter reached its limit before stop |
| coarse_cnt | output | CNT_W | Coarse count result |

## Verification
The bench targets the exact length of the post-stop phase at every accuracy setting and with the phase disabled. An off-by-one or a wrong factor table would move `ready` by one or more cycles. Calibration runs at all four divide factors and in both one-period and two-period form, which exposes a divider that counts the wrong number of edges or a CAL2 that stops on its first tick. Other runs extend past the counter limit, clear the trigger in mid-count, wiggle START during counting, and raise a calibration request while enabled. A design that restarts on a late edge, loses the overflow flag or lets calibration run with the channel enabled would produce the wrong count or a stray `ready`.

// File: rtl/tdc_seq_pkg.sv
package tdc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WSTART, S_WSTOP, S_CHAR, S_CALC, S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    M_TIME, M_CAL1, M_CAL2
  } seq_mode_e;

  // Accuracy factor for the characteristic-quantity phase.
  function automatic int acc_factor(input logic [1:0] sel);
    return 1 << (sel == 2'd3 ? 5 : 2 * int'(sel));
  endfunction

  // Cycles spent in the characteristic-quantity phase.
  function automatic int char_cycles(input logic en, input logic [1:0] sel, input int base);
    return base * (1 + 8 * (en ? acc_factor(sel) : 0));
  endfunction

  function automatic int div_factor(input logic [1:0] sel);
    return 1 << int'(sel);
  endfunction

endpackage

// File: rtl/tdc_sync_edge.sv
module tdc_sync_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  localparam int STAGES = 3;
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= din;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_edge
      assign rise[g] = st[1][g] & ~st[2][g];
    end
  endgenerate
endmodule

// File: rtl/tdc_cal_div.sv
module tdc_cal_div
  import tdc_seq_pkg::*;
#(
  parameter int MAX_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] div_sel,
  input  logic       cal_rise,
  output logic       tick
);
  localparam int DW = $clog2(MAX_DIV);
  logic [DW-1:0] cnt;
  logic [DW-1:0] last;

  assign last = DW'(div_factor(div_sel) - 1);
  assign tick = cal_rise && !clr && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (tick)     cnt <= '0;
    else if (cal_rise) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tdc_seq_fsm.sv
module tdc_seq_fsm
  import tdc_seq_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int BASE_CYC = 4,
  parameter int CALC_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             cal1_req,
  input  logic             cal2_req,
  input  logic             char_en,
  input  logic [1:0]       acc_sel,
  input  logic [1:0]       div_sel,
  input  logic             start_rise,
  input  logic             stop_rise,
  input  logic             tick,
  output logic [1:0]       div_q,
  output logic             in_idle,
  output logic             cnt_run,
  output logic             calc_last,
  output logic             ready,
  output logic             busy,
  output logic             core_ovf,
  output logic [CNT_W-1:0] coarse_cnt
);
  localparam int MAX_PH = BASE_CYC * 257 + CALC_CYC;
  localparam int PH_W   = $clog2(MAX_PH + 1);

  seq_state_e       state;
  seq_mode_e        mode;
  logic [PH_W-1:0]  ph;
  logic             char_q;
  logic [1:0]       acc_q;
  logic             tick_seen;
  logic             trig, st_ev, sp_ev;
  logic [PH_W-1:0]  char_last;

  always_comb begin
    unique case (mode)
      M_CAL1:  trig = cal1_req;
      M_CAL2:  trig = cal2_req;
      default: trig = chan_en;
    endcase
    st_ev = (mode == M_TIME) ? start_rise : tick;
    sp_ev = (mode == M_TIME) ? stop_rise
                             : (tick && (mode == M_CAL1 || tick_seen));
  end

  assign char_last = PH_W'(char_cycles(char_q, acc_q, BASE_CYC) - 1);
  assign in_idle   = (state == S_IDLE);
  assign cnt_run   = (state == S_WSTOP);
  assign calc_last = (state == S_CALC) && (ph == '0);
  assign ready     = (state == S_DONE);
  assign busy      = (state == S_WSTOP) || (state == S_CHAR) || (state == S_CALC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      mode       <= M_TIME;
      ph         <= '0;
      char_q     <= 1'b0;
      acc_q      <= '0;
      div_q      <= '0;
      tick_seen  <= 1'b0;
      core_ovf   <= 1'b0;
      coarse_cnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (chan_en || cal1_req || cal2_req) begin
            mode       <= chan_en ? M_TIME : (cal1_req ? M_CAL1 : M_CAL2);
            state      <= S_WSTART;
            core_ovf   <= 1'b0;
            coarse_cnt <= '0;
            tick_seen  <= 1'b0;
            char_q     <= char_en;
            acc_q      <= acc_sel;
            div_q      <= div_sel;
          end
        end
        S_WSTART: begin
          if (!trig) state <= S_IDLE;
          else if (st_ev) begin
            state      <= S_WSTOP;
            coarse_cnt <= '0;
            tick_seen  <= 1'b0;
          end
        end
        S_WSTOP: begin
          if (!trig) state <= S_IDLE;
          else if (&coarse_cnt) begin
            core_ovf <= 1'b1;
            state    <= S_CHAR;
            ph       <= char_last;
          end else begin
            coarse_cnt <= coarse_cnt + 1'b1;
            if (sp_ev) begin
              state <= S_CHAR;
              ph    <= char_last;
            end else if (tick) begin
              tick_seen <= 1'b1;
            end
          end
        end
        S_CHAR: begin
          if (ph == '0) begin
            state <= S_CALC;
            ph    <= PH_W'(CALC_CYC - 1);
          end else ph <= ph - 1'b1;
        end
        S_CALC: begin
          if (ph == '0) state <= S_DONE;
          else          ph    <= ph - 1'b1;
        end
        S_DONE: if (!trig) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdc_seq.sv
module tdc_seq
  import tdc_seq_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int BASE_CYC = 4,
  parameter int CALC_CYC = 3,
  parameter int MAX_DIV  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             cal1_req,
  input  logic             cal2_req,
  input  logic             char_en,
  input  logic [1:0]       acc_sel,
  input  logic [1:0]       div_sel,
  input  logic             start_in,
  input  logic             stop_in,
  input  logic             cal_clk_in,
  output logic             ready,
  output logic             busy,
  output logic             core_ovf,
  output logic [CNT_W-1:0] coarse_cnt
);
  logic [2:0] rise;
  logic [1:0] div_q;
  logic       tick, in_idle, cnt_run, calc_last;

  tdc_sync_edge #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cal_clk_in, stop_in, start_in}),
    .rise (rise)
  );

  tdc_cal_div #(.MAX_DIV(MAX_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (in_idle),
    .div_sel (div_q),
    .cal_rise(rise[2]),
    .tick    (tick)
  );

  tdc_seq_fsm #(.CNT_W(CNT_W), .BASE_CYC(BASE_CYC), .CALC_CYC(CALC_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .cal1_req  (cal1_req),
    .cal2_req  (cal2_req),
    .char_en   (char_en),
    .acc_sel   (acc_sel),
    .div_sel   (div_sel),
    .start_rise(rise[0]),
    .stop_rise (rise[1]),
    .tick      (tick),
    .div_q     (div_q),
    .in_idle   (in_idle),
    .cnt_run   (cnt_run),
    .calc_last (calc_last),
    .ready     (ready),
    .busy      (busy),
    .core_ovf  (core_ovf),
    .coarse_cnt(coarse_cnt)
  );
endmodule

// File: rtl/tdc_seq_chk.sv
module tdc_seq_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             cal1_req,
  input logic             cal2_req,
  input logic             in_idle,
  input logic             cnt_run,
  input logic             calc_last,
  input logic             ready,
  input logic             busy,
  input logic             core_ovf,
  input logic [CNT_W-1:0] coarse_cnt
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_run && $past(cnt_run) |-> coarse_cnt == CNT_W'($past(coarse_cnt) + 1'b1)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && !chan_en && !cal1_req && !cal2_req |=> !busy && !ready); // R2

  AST_READY_AFTER_CALC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(calc_last)); // R6

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ready && $past(ready) |-> $stable(coarse_cnt) && $stable(core_ovf)); // R7

  AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_ovf) |-> &coarse_cnt); // R9
endmodule

bind tdc_seq tdc_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .cal1_req  (cal1_req),
  .cal2_req  (cal2_req),
  .in_idle   (in_idle),
  .cnt_run   (cnt_run),
  .calc_last (calc_last),
  .ready     (ready),
  .busy      (busy),
  .core_ovf  (core_ovf),
  .coarse_cnt(coarse_cnt)
);

// File: tb/tdc_seq_tb.sv
`timescale 1ns/1ps
module tdc_seq_tb;
  localparam int CNT_W = 8;
  localparam int BASE  = 2;
  localparam int CALC  = 3;
  localparam int CPER  = 6;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 0, cal1_req = 0, cal2_req = 0, char_en = 0;
  logic [1:0] acc_sel = 0, div_sel = 0;
  logic start_in = 0, stop_in = 0, cal_clk_in = 0;
  logic ready, busy, core_ovf;
  logic [CNT_W-1:0] coarse_cnt;

  int vectors = 0, fails = 0, cyc = 0, ccount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tdc_seq #(.CNT_W(CNT_W), .BASE_CYC(BASE), .CALC_CYC(CALC)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cal1_req(cal1_req),
    .cal2_req(cal2_req), .char_en(char_en), .acc_sel(acc_sel), .div_sel(div_sel),
    .start_in(start_in), .stop_in(stop_in), .cal_clk_in(cal_clk_in),
    .ready(ready), .busy(busy), .core_ovf(core_ovf), .coarse_cnt(coarse_cnt));

  always @(negedge clk) begin
    ccount <= (ccount + 1) % CPER;
    cal_clk_in <= (ccount < CPER / 2);
  end

  // ---------------- behavioural reference ----------------
  int ms = 0, mmode = 0, mcnt = 0, movf = 0, mleft = 0, mdivn = 1, mlen = 0, mdivc = 0;
  bit mts = 0;
  bit [2:0] hst = 0, hsp = 0, hcl = 0;

  function automatic int fac(input int s);
    case (s) 0: return 1; 1: return 4; 2: return 16; default: return 32; endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mmode = 0; mcnt = 0; movf = 0; mleft = 0; mts = 0; mdivc = 0; mdivn = 1;
      hst = 0; hsp = 0; hcl = 0;
    end else begin
      bit sr, pr, cr, tk, trig, sev, pev;
      sr = hst[1] & ~hst[2];
      pr = hsp[1] & ~hsp[2];
      cr = hcl[1] & ~hcl[2];
      tk = 0;
      if (ms == 0) mdivc = 0;
      else if (cr) begin
        mdivc++;
        if (mdivc % mdivn == 0) tk = 1;
      end
      trig = (mmode == 0) ? chan_en : (mmode == 1) ? cal1_req : cal2_req;
      sev  = (mmode == 0) ? sr : tk;
      pev  = (mmode == 0) ? pr : (tk && (mmode == 1 || mts));
      case (ms)
        0: if (chan_en || cal1_req || cal2_req) begin
             mmode = chan_en ? 0 : (cal1_req ? 1 : 2);
             ms = 1; movf = 0; mcnt = 0; mts = 0;
             mdivn = 1 << div_sel;
             mlen = BASE * (1 + 8 * (char_en ? fac(acc_sel) : 0));
           end
        1: if (!trig) ms = 0; else if (sev) begin ms = 2; mcnt = 0; mts = 0; end
        2: if (!trig) ms = 0;
           else if (mcnt == MAXC) begin movf = 1; ms = 3; mleft = mlen; end
           else begin
             mcnt++;
             if (pev) begin ms = 3; mleft = mlen; end
             else if (tk) mts = 1;
           end
        3: begin mleft--; if (mleft == 0) begin ms = 4; mleft = CALC; end end
        4: begin mleft--; if (mleft == 0) ms = 5; end
        default: if (!trig) ms = 0;
      endcase
      hst = {hst[1:0], start_in};
      hsp = {hsp[1:0], stop_in};
      hcl = {hcl[1:0], cal_clk_in};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (ready !== (ms == 5)) begin fails++; $display("FAIL R6 model ready act=%0b exp=%0b", ready, ms == 5); end
      if (busy !== (ms >= 2 && ms <= 4)) begin fails++; $display("FAIL R8 model busy act=%0b exp=%0b", busy, ms >= 2 && ms <= 4); end
      if (int'(coarse_cnt) != mcnt) begin fails++; $display("FAIL R1 model coarse act=%0d exp=%0d", coarse_cnt, mcnt); end
      if (int'(core_ovf) != movf) begin fails++; $display("FAIL R9 model ovf act=%0b exp=%0d", core_ovf, movf); end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin fails++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      finish_run();
    end
  end

  task automatic wait_ready(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ready && n < 3000);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic time_meas(input int d, input bit wiggle, input int exp_lat, input string tag);
    int n;
    @(negedge clk); chan_en = 1;
    idle_cycles(4);
    if (wiggle) begin stop_in = 1; idle_cycles(3); stop_in = 0; idle_cycles(3); end
    start_in = 1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      if (wiggle && i == 3) start_in = 0;
      if (wiggle && i == 6) start_in = 1;
    end
    stop_in = 1;
    wait_ready(n);
    chk(n == exp_lat, {tag, " ready latency"}, n, exp_lat);
    chk(int'(coarse_cnt) == d, {tag, " coarse"}, coarse_cnt, d);
    if (wiggle) begin start_in = 0; stop_in = 0; idle_cycles(3); start_in = 1; stop_in = 1; end
    idle_cycles(5);
    chk(ready && int'(coarse_cnt) == d, "R8 R7 result held", coarse_cnt, d);
    start_in = 0; stop_in = 0;
    chan_en = 0;
    @(negedge clk);
    chk(!ready, "R7 ready falls", ready, 0);
    idle_cycles(3);
  endtask

  task automatic cal_meas(input int which, input int dsel, input int exp, input string tag);
    int n;
    @(negedge clk);
    div_sel = 2'(dsel);
    if (which == 1) cal1_req = 1; else cal2_req = 1;
    idle_cycles(2);
    start_in = 1; idle_cycles(2); stop_in = 1; idle_cycles(2); start_in = 0; stop_in = 0;
    wait_ready(n);
    chk(ready, {tag, " ready"}, ready, 1);
    chk(int'(coarse_cnt) == exp, {tag, " coarse"}, coarse_cnt, exp);
    cal1_req = 0; cal2_req = 0;
    @(negedge clk);
    chk(!ready, "R7 cal ready falls", ready, 0);
    idle_cycles(3);
  endtask

  initial begin
    int n;
    idle_cycles(4);
    rst_n = 1;
    @(negedge clk);
    chk(!ready && !busy && !core_ovf && coarse_cnt == 0, "R12 reset state", int'(coarse_cnt), 0);

    // R2: disabled channel ignores start/stop
    start_in = 1; idle_cycles(5); stop_in = 1; idle_cycles(5); start_in = 0; stop_in = 0;
    idle_cycles(20);
    chk(!ready && !busy, "R2 disabled ignores edges", int'(ready) + int'(busy), 0);

    // R1 and R6 with the characteristic phase disabled
    char_en = 0;
    time_meas(20, 0, BASE + CALC + 3, "R1");
    time_meas(37, 0, BASE + CALC + 3, "R1");
    // R8: stray stop before start, start wiggles during counting
    time_meas(15, 1, BASE + CALC + 3, "R8");

    // R6 accuracy sweep
    char_en = 1;
    for (int a = 0; a < 4; a++) begin
      acc_sel = 2'(a);
      time_meas(10, 0, BASE * (1 + 8 * fac(a)) + CALC + 3, "R6");
    end
    char_en = 0; acc_sel = 0;

    // R3 and R5: one period at every divide factor
    for (int dv = 0; dv < 4; dv++) cal_meas(1, dv, (1 << dv) * CPER, "R3 R5");
    // R4: two periods
    cal_meas(2, 1, 2 * 2 * CPER, "R4");
    cal_meas(2, 3, 2 * 8 * CPER, "R4");

    // R10: calibration request ignored while enabled
    @(negedge clk); chan_en = 1; cal1_req = 1;
    idle_cycles(60);
    chk(!ready && !busy, "R10 cal ignored when enabled", int'(ready), 0);
    start_in = 1; idle_cycles(12); stop_in = 1;
    wait_ready(n);
    chk(int'(coarse_cnt) == 12, "R10 time mode taken", coarse_cnt, 12);
    chan_en = 0; cal1_req = 0; start_in = 0; stop_in = 0; idle_cycles(4);
    // R10: CAL1 wins over CAL2
    @(negedge clk); div_sel = 2; cal1_req = 1; cal2_req = 1;
    wait_ready(n);
    chk(int'(coarse_cnt) == 4 * CPER, "R10 cal1 precedence", coarse_cnt, 4 * CPER);
    cal1_req = 0; cal2_req = 0; idle_cycles(4);

    // R9: overflow
    @(negedge clk); chan_en = 1; idle_cycles(3); start_in = 1;
    wait_ready(n);
    chk(core_ovf == 1'b1, "R9 overflow flag", core_ovf, 1);
    chk(int'(coarse_cnt) == MAXC, "R9 coarse at max", coarse_cnt, MAXC);
    chan_en = 0; start_in = 0; idle_cycles(4);
    time_meas(9, 0, BASE + CALC + 3, "R1");
    chk(!core_ovf, "R9 flag cleared by next run", core_ovf, 0);

    // R11: abandon while counting
    @(negedge clk); chan_en = 1; idle_cycles(3); start_in = 1; idle_cycles(8);
    chan_en = 0; idle_cycles(2);
    chk(!busy, "R11 busy drops on abandon", busy, 0);
    stop_in = 1; idle_cycles(30);
    chk(!ready && !busy, "R11 no ready after abandon", ready, 0);
    start_in = 0; stop_in = 0; idle_cycles(4);

    finish_run();
  end
endmodule